// File: doc/BRIEF.md
# Multi-Mode Handshaked Parallel Port

This block is one 8-bit parallel port that a processor programs through a single-cycle register interface. The interface has one select line that chooses between the control register and the data register. The port keeps an input data register and an output data register. It sequences a strobe/ready handshake with the attached peripheral. It runs in one of four modes: byte output, byte input, bidirectional, and bit control. In bit-control mode each pin is set as an input or an output, and an interrupt is requested when the unmasked input pins reach a programmed condition.

The pins leave the block as separate input, output and per-bit drive-enable signals, so the pad ring provides any tristate buffering. Interrupt requests appear as single-cycle pulses on `irq`, for use by a separate priority-chain block. The whole block is synchronous to `clk`, and `rst` is a synchronous, active-high reset. A second copy of the port can be built with bidirectional operation disabled through the `BIDIR_OK` parameter.

Top module: `pport`

## Requirements
- R1: After reset, the port is in input mode with `rdy`=1, `irdy`=0, `irq`=0 and `pin_oe`=0. Interrupts are disabled, all pins are inputs and all pins are masked.
- R2: A control write whose low nibble is 1111 is a mode word, and bits 7:6 select the mode: 00 output, 01 input, 10 bidirectional, 11 bit control. Entering output mode gives `pin_oe`=all ones and `rdy`=0. Entering input mode gives `pin_oe`=0 and `rdy`=1. Entering bidirectional mode gives `rdy`=0 and `irdy`=1. After a bit-control mode word, the next control write loads the direction register (1 = input, 0 = output).
- R3: With `BIDIR_OK`=0, a mode word selecting bidirectional is ignored and the mode does not change.
- R4: In output mode, a data write drives the byte on `pin_out` and sets `rdy` on the next cycle. A falling edge on `stb_n` clears `rdy` on the next cycle.
- R5: In input mode, a falling edge on `stb_n` latches `pin_in` into the input register and clears `rdy`. A data read returns the input register and sets `rdy` on the next cycle.
- R6: In bidirectional mode, `pin_oe` is all ones only while `stb_n` is low. A `stb_n` fall clears `rdy`, and a data write sets it. An `istb_n` fall latches `pin_in` and clears `irdy`, and a data read sets `irdy`.
- R7: A control write whose low nibble is 0111 is an interrupt word. Bit 7 is the enable. Bit 6 selects the combine rule (1 = all, 0 = any). Bit 5 selects the active level (1 = high, 0 = low). Bit 4 set means the next control write loads the mask register, where 1 excludes a pin. Each interrupt is a one-cycle pulse on `irq`.
- R8: In bit-control mode, `pin_oe` is the inverse of the direction register and `pin_out` carries the output register. A data read returns `pin_in` on input bits and the output register on output bits.
- R9: In bit-control mode, the monitored pins are the unmasked input pins. The match holds when any monitored pin is at the active level ("any" rule), or when every monitored pin is at that level and at least one pin is monitored ("all" rule). `irq` pulses one cycle after the match begins and does not pulse again while the match holds.
- R10: While interrupts are disabled, no `irq` pulse occurs. Enabling them while a bit-mode match already holds gives no pulse.
- R11: A control write that is not awaited as a direction or mask word and whose low nibble is neither 1111 nor 0111 has no effect.
- R12: Strobes act on the falling edge only. A strobe held low for several cycles counts as one event and gives one `irq` pulse. In the byte modes, each such event pulses `irq` when interrupts are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_wr | input | 1 | Single-cycle write strobe |
| cpu_rd | input | 1 | Single-cycle read strobe |
| cpu_sel_ctrl | input | 1 | 1 selects the control register, 0 selects the data register |
| cpu_wdata | input | W | Write data |
| cpu_rdata | output | W | Read data of the data register |
| pin_in | input | W | Pin input values |
| pin_out | output | W | Pin output values |
| pin_oe | output | W | Per-pin drive enable |
| stb_n | input | 1 | Peripheral strobe, active low |
| rdy | output | 1 | Ready toward the peripheral (output side in bidirectional mode) |
| istb_n | input | 1 | Input-side strobe in bidirectional mode, active low |
| irdy | output | 1 | Input-side ready in bidirectional mode |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
The assertions check the following on every cycle:
- A strobe fall in output mode always drops ready.
- A strobe fall in input mode always latches the pins.
- No pulse leaves the block while interrupts are disabled.
- A standing bit-mode match never pulses again.
- Pulses last exactly one cycle.
- A port built without bidirectional support never enters that mode.

Only the bench scenarios can show the control-word sequencing, which covers the direction and mask words that follow a mode or interrupt word and the ignored words. The scenarios also cover the any/all and high/low match rules with masked pins, the read-back mix of pins and output register, and the suppression of a pulse when interrupts are enabled during a standing match.

// File: rtl/pport.sv
module pport #(
  parameter int W = 8,
  parameter bit BIDIR_OK = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cpu_wr,
  input  logic         cpu_rd,
  input  logic         cpu_sel_ctrl,
  input  logic [W-1:0] cpu_wdata,
  output logic [W-1:0] cpu_rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  input  logic         stb_n,
  output logic         rdy,
  input  logic         istb_n,
  output logic         irdy,
  output logic         irq
);
  localparam logic [1:0] M_OUT = 2'd0, M_IN = 2'd1, M_BID = 2'd2, M_BIT = 2'd3;

  logic [1:0]   mode;
  logic [W-1:0] out_q, in_q, dir_q, mask_q;
  logic         ie_q, all_q, high_q, want_dir, want_mask;
  logic         stb_q, istb_q, match_q;

  logic data_wr, ctrl_wr, data_rd, stb_fall, istb_fall;
  logic [1:0] new_mode;
  logic mode_ok, match, bitmode, bit_hit, byte_evt;
  logic [W-1:0] watch, act;

  assign data_wr   = cpu_wr & ~cpu_sel_ctrl;
  assign ctrl_wr   = cpu_wr & cpu_sel_ctrl;
  assign data_rd   = cpu_rd & ~cpu_sel_ctrl;
  assign stb_fall  = stb_q & ~stb_n;
  assign istb_fall = istb_q & ~istb_n;
  assign new_mode  = cpu_wdata[7:6];
  assign mode_ok   = (new_mode != M_BID) || BIDIR_OK;

  assign watch   = ~mask_q & dir_q;
  assign act     = high_q ? pin_in : ~pin_in;
  assign match   = all_q ? ((watch != '0) && ((act & watch) == watch)) : |(act & watch);
  assign bitmode = (mode == M_BIT);
  assign bit_hit = bitmode & match & ~match_q;
  assign byte_evt = ((mode == M_OUT || mode == M_IN) && stb_fall) ||
                    ((mode == M_BID) && (stb_fall || istb_fall));

  assign pin_out = out_q;

  always_comb begin
    case (mode)
      M_OUT:   begin pin_oe = '1;          cpu_rdata = out_q; end
      M_IN:    begin pin_oe = '0;          cpu_rdata = in_q;  end
      M_BID:   begin pin_oe = {W{~stb_n}}; cpu_rdata = in_q;  end
      default: begin pin_oe = ~dir_q;      cpu_rdata = (pin_in & dir_q) | (out_q & ~dir_q); end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= M_IN;
      out_q     <= '0;
      in_q      <= '0;
      dir_q     <= '1;
      mask_q    <= '1;
      ie_q      <= 1'b0;
      all_q     <= 1'b0;
      high_q    <= 1'b0;
      want_dir  <= 1'b0;
      want_mask <= 1'b0;
      stb_q     <= 1'b1;
      istb_q    <= 1'b1;
      rdy       <= 1'b1;
      irdy      <= 1'b0;
      match_q   <= 1'b0;
      irq       <= 1'b0;
    end else begin
      stb_q   <= stb_n;
      istb_q  <= istb_n;
      match_q <= bitmode & match;
      irq     <= ie_q & (bit_hit | byte_evt);
      if (data_wr) out_q <= cpu_wdata;

      case (mode)
        M_OUT: begin
          if (stb_fall) rdy <= 1'b0;
          if (data_wr)  rdy <= 1'b1;
        end
        M_IN: begin
          if (data_rd) rdy <= 1'b1;
          if (stb_fall) begin in_q <= pin_in; rdy <= 1'b0; end
        end
        M_BID: begin
          if (stb_fall) rdy  <= 1'b0;
          if (data_wr)  rdy  <= 1'b1;
          if (data_rd)  irdy <= 1'b1;
          if (istb_fall) begin in_q <= pin_in; irdy <= 1'b0; end
        end
        default: ;
      endcase

      if (ctrl_wr) begin
        if (want_dir) begin
          dir_q    <= cpu_wdata;
          want_dir <= 1'b0;
        end else if (want_mask) begin
          mask_q    <= cpu_wdata;
          want_mask <= 1'b0;
        end else if (cpu_wdata[3:0] == 4'hF) begin
          if (mode_ok) begin
            mode     <= new_mode;
            want_dir <= (new_mode == M_BIT);
            rdy      <= (new_mode == M_IN);
            irdy     <= (new_mode == M_BID);
          end
        end else if (cpu_wdata[3:0] == 4'h7) begin
          ie_q      <= cpu_wdata[7];
          all_q     <= cpu_wdata[6];
          high_q    <= cpu_wdata[5];
          want_mask <= cpu_wdata[4];
        end
      end
    end
  end
endmodule

// File: rtl/pport_chk.sv
module pport_chk #(
  parameter int W = 8,
  parameter bit BIDIR_OK = 1'b1
) (
  input logic         clk,
  input logic         rst,
  input logic         cpu_wr,
  input logic [W-1:0] cpu_rdata,
  input logic [W-1:0] pin_in,
  input logic         stb_n,
  input logic         rdy,
  input logic         irq,
  input logic [1:0]   mode,
  input logic         ie_q,
  input logic         match_q
);
  a_r4_strobe_drops_rdy: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 && $fell(stb_n) && !cpu_wr) |=> !rdy);

  a_r5_strobe_latches: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && $fell(stb_n) && !cpu_wr) |=> (cpu_rdata == $past(pin_in)));

  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ie_q));

  a_r9_no_repeat_on_hold: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3 && match_q) |=> !irq);

  a_r7_one_cycle_pulse: assert property (@(posedge clk) disable iff (rst)
    (irq && mode != 2'd2 && !$past(cpu_wr)) |=> !irq);

  a_r3_no_bidir: assert property (@(posedge clk) disable iff (rst)
    !BIDIR_OK |-> (mode != 2'd2));
endmodule

bind pport pport_chk #(.W(W), .BIDIR_OK(BIDIR_OK)) u_chk (
  .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .pin_in(pin_in),
  .stb_n(stb_n), .rdy(rdy), .irq(irq), .mode(mode), .ie_q(ie_q), .match_q(match_q)
);

// File: tb/tb_pport.sv
module tb_pport;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_sel_ctrl = 1'b0;
  logic [7:0] cpu_wdata = '0, pin_in = '0;
  logic stb_n = 1'b1, istb_n = 1'b1;
  logic [7:0] cpu_rdata, pin_out, pin_oe, rdata_nb, pout_nb, poe_nb;
  logic rdy, irdy, irq, rdy_nb, irdy_nb, irq_nb;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pport #(.W(8), .BIDIR_OK(1'b1)) dut (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_sel_ctrl(cpu_sel_ctrl),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .stb_n(stb_n), .rdy(rdy), .istb_n(istb_n), .irdy(irdy), .irq(irq));

  pport #(.W(8), .BIDIR_OK(1'b0)) dut_nb (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_sel_ctrl(cpu_sel_ctrl),
    .cpu_wdata(cpu_wdata), .cpu_rdata(rdata_nb), .pin_in(pin_in), .pin_out(pout_nb),
    .pin_oe(poe_nb), .stb_n(stb_n), .rdy(rdy_nb), .istb_n(istb_n), .irdy(irdy_nb), .irq(irq_nb));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic cwr(input logic [7:0] d);
    @(negedge clk); cpu_wr = 1'b1; cpu_sel_ctrl = 1'b1; cpu_wdata = d;
    @(negedge clk); cpu_wr = 1'b0; cpu_sel_ctrl = 1'b0;
  endtask

  task automatic dwr(input logic [7:0] d);
    @(negedge clk); cpu_wr = 1'b1; cpu_sel_ctrl = 1'b0; cpu_wdata = d;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic drd();
    @(negedge clk); cpu_rd = 1'b1; cpu_sel_ctrl = 1'b0;
    @(negedge clk); cpu_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rdy", rdy, 1); chk("R1 irdy", irdy, 0);
    chk("R1 irq", irq, 0); chk("R1 pin_oe", pin_oe, 8'h00);
  endtask

  task automatic t_output();
    cwr(8'h0F);
    chk("R2 out oe", pin_oe, 8'hFF); chk("R2 out rdy", rdy, 0);
    cwr(8'h4B);
    chk("R11 ignored word", pin_oe, 8'hFF);
    cwr(8'h87);
    dwr(8'hA5);
    chk("R4 pin_out", pin_out, 8'hA5); chk("R4 rdy set", rdy, 1);
    @(negedge clk); stb_n = 1'b0;
    cyc();
    chk("R4 rdy clr", rdy, 0); chk("R12 irq", irq, 1);
    cyc(); chk("R12 pulse ends", irq, 0);
    cyc(); cyc(); chk("R12 held low no repeat", irq, 0);
    stb_n = 1'b1; cyc();
  endtask

  task automatic t_input();
    cwr(8'h4F);
    chk("R2 in oe", pin_oe, 8'h00); chk("R2 in rdy", rdy, 1);
    pin_in = 8'h3C; stb_n = 1'b0;
    cyc();
    chk("R5 rdy clr", rdy, 0); chk("R5 irq", irq, 1); chk("R5 latched", cpu_rdata, 8'h3C);
    pin_in = 8'h00; stb_n = 1'b1; cyc();
    chk("R5 held", cpu_rdata, 8'h3C);
    drd();
    chk("R5 read sets rdy", rdy, 1);
  endtask

  task automatic t_disabled();
    cwr(8'h07);
    pin_in = 8'h96; stb_n = 1'b0;
    cyc();
    chk("R10 no irq", irq, 0); chk("R10 still latched", cpu_rdata, 8'h96);
    stb_n = 1'b1; pin_in = 8'h00; cyc();
  endtask

  task automatic t_bidir();
    cwr(8'h87);
    cwr(8'h8F);
    chk("R2 bid rdy", rdy, 0); chk("R2 bid irdy", irdy, 1); chk("R6 oe idle", pin_oe, 8'h00);
    dwr(8'h5A);
    chk("R6 rdy set", rdy, 1); chk("R6 pin_out", pin_out, 8'h5A);
    stb_n = 1'b0; cyc();
    chk("R6 oe on strobe", pin_oe, 8'hFF); chk("R6 rdy clr", rdy, 0); chk("R6 irq out", irq, 1);
    chk("R3 no bidir in dut_nb", poe_nb, 8'h00);
    stb_n = 1'b1; cyc();
    chk("R6 oe released", pin_oe, 8'h00);
    pin_in = 8'h81; istb_n = 1'b0; cyc();
    chk("R6 irdy clr", irdy, 0); chk("R6 in latch", cpu_rdata, 8'h81); chk("R6 irq in", irq, 1);
    istb_n = 1'b1; pin_in = 8'h00; cyc();
    drd();
    chk("R6 read sets irdy", irdy, 1);
  endtask

  task automatic t_bit_any_high();
    cwr(8'hCF);
    cwr(8'hF0);
    cwr(8'hB7);
    cwr(8'h30);
    dwr(8'h0C);
    chk("R8 oe", pin_oe, 8'h0F); chk("R8 pin_out", pin_out, 8'h0C);
    pin_in = 8'h3F; cyc(); cyc();
    chk("R8 read mix", cpu_rdata, 8'h3C); chk("R9 masked no irq", irq, 0);
    pin_in = 8'h80; cyc();
    chk("R9 any high irq", irq, 1);
    cyc(); chk("R9 pulse ends", irq, 0);
    pin_in = 8'hC0; cyc(); chk("R9 still matching no irq", irq, 0);
    pin_in = 8'h00; cyc(); chk("R9 no match", irq, 0);
    pin_in = 8'h40; cyc(); chk("R9 new match irq", irq, 1);
    cyc();
  endtask

  task automatic t_bit_all_low();
    cwr(8'hC7);
    pin_in = 8'h80; cyc(); cyc(); chk("R9 all low partial", irq, 0);
    pin_in = 8'h00; cyc(); chk("R9 all low irq", irq, 1);
    cyc();
  endtask

  task automatic t_late_enable();
    cwr(8'h47);
    pin_in = 8'h80; cyc(); cyc();
    pin_in = 8'h00; cyc(); chk("R10 disabled match", irq, 0);
    cwr(8'hC7);
    cyc(); chk("R10 enable during match", irq, 0);
    cyc(); chk("R10 enable during match later", irq, 0);
  endtask

  task automatic t_nobidir();
    cwr(8'h0F);
    cwr(8'h8F);
    stb_n = 1'b0; cyc();
    chk("R3 mode kept", poe_nb, 8'hFF);
    stb_n = 1'b1; cyc();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cyc();
    t_reset();
    t_output();
    t_input();
    t_disabled();
    t_bidir();
    t_bit_any_high();
    t_bit_all_low();
    t_late_enable();
    t_nobidir();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule